// File: doc/BRIEF.md
# Write-Back Data Cache with Line Flush and Uncached Bypass

This block sits between a processor load/store port and a single-word memory bus. It holds recently used memory lines in a direct-mapped store. Each line holds four 32-bit words and has a tag, a valid flag and a dirty flag. Cached stores write only into the cache. Modified lines reach memory later, when they are evicted or flushed. A cached miss first writes back a dirty victim if there is one, then refills the line and completes the access. Stores allocate a line on a miss.

Software controls coherency by hand, because the block never watches memory traffic from other masters. Three tools are provided for this:
- A flush-line command writes a dirty resident line back to memory and invalidates it.
- An I/O flag on a request sends a load or store straight to memory.
- Setting bit 31 of an ordinary address has the same effect as the I/O flag, so the cacheability of an address travels with the pointer.

The memory bus never sees bit 31 set. When the line count parameter is zero, the cache is absent: every load and store goes to memory, and a flush retires in one cycle.

Top module: `wb_dcache`

## Requirements
- R1: A cached store that hits writes only into the cache and marks the line dirty. It issues no memory write, and memory keeps its old word until that line is written back.
- R2: A cached access that misses on a line that is invalid or clean issues no memory write. It reads the four words of the new line in ascending address order, then completes. A load returns the requested word, and a store allocates the line and updates it.
- R3: A cached miss whose victim line is dirty first writes the victim's four words in ascending order to the victim's own address. Only then does it read the new line.
- R4: A flush-line command (op code 2) on a matching dirty line writes its four words to memory, then invalidates the line, so the next access to that line refills it.
- R5: A flush-line command on a matching clean line invalidates it without any memory traffic. A flush on a line whose tag does not match changes nothing and issues no memory access.
- R6: A load or store with the I/O flag set makes exactly one memory access and neither reads nor changes the cache, even when the address is resident.
- R7: A load or store (op codes 0 and 1) with address bit 31 set behaves exactly like an I/O access.
- R8: Address bit 31 is zero on every memory bus request.
- R9: While a memory request waits for its acknowledge, its address, write flag and write data stay unchanged.
- R10: A write to memory by another master does not change a resident cached word. A later cached load still returns the cached value.
- R11: With zero lines, a flush-line command is accepted and ready returns one cycle later with no memory access. Loads and stores go to memory one word at a time.
- R12: After reset the block is ready, issues no memory request and no response, and all lines are invalid.
- R13: Every load returns its data with a response-valid pulse that lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 flush line |
| req_io | input | 1 | Uncached access flag |
| req_addr | input | 32 | Byte address; bit 31 forces an uncached access |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle pulse with load data |
| rsp_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, bit 31 always zero |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rdata | input | 32 | Memory read data, valid with the acknowledge |

## Verification
The bench builds situations in which the cache and memory hold different values for the same address. If a design let a store hit write through to memory, an uncached read would then show the new value. If a design let the cache see a bypassed store, the cached value would be replaced. If a design skipped the write-back of a dirty victim, the evicted data would be lost when the line is read again. The bench also logs the order of bus addresses during eviction and refill, under a slow acknowledge, to catch a refill that starts before the write-back or a request that changes while it waits. Flushes on clean lines, on lines with a different tag and on the cache-less build must produce no bus traffic, and only a matching flush may cause a refill.

// File: rtl/wb_dcache.sv
module wb_dcache #(
  parameter int LINES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic        req_io,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam bit EN  = LINES > 0;
  localparam int NL  = EN ? LINES : 1;
  localparam int IW  = NL > 1 ? $clog2(NL) : 1;
  localparam int WIW = IW + 2;
  localparam int NW  = 1 << WIW;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_FL = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_WB, S_FILL, S_DONE, S_BYP} st_t;

  st_t          st;
  logic [26:0]  tag_q [NL];
  logic [NL-1:0] val_q, dty_q;
  logic [31:0]  dat_q [NW];
  logic [1:0]   r_op, cnt;
  logic [30:0]  r_addr;
  logic [31:0]  r_wdata;
  logic [IW-1:0] r_idx;

  logic [26:0]   line_in;
  logic [IW-1:0] idx_in;
  logic          hit_in, byp_in, accept;

  assign line_in = req_addr[30:4];
  assign idx_in  = IW'(line_in % 27'(NL));
  assign hit_in  = EN && val_q[idx_in] && (tag_q[idx_in] == line_in);
  assign byp_in  = req_io || req_addr[31] || !EN;
  assign accept  = (st == S_IDLE) && req_valid;

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_WB) || (st == S_FILL) || (st == S_BYP);
  assign mem_we    = (st == S_WB) || (st == S_BYP && r_op == OP_ST);
  assign mem_wdata = (st == S_WB) ? dat_q[{r_idx, cnt}] : r_wdata;

  always_comb begin
    case (st)
      S_WB:    mem_addr = {1'b0, tag_q[r_idx], cnt, 2'b00};
      S_FILL:  mem_addr = {1'b0, r_addr[30:4], cnt, 2'b00};
      default: mem_addr = {1'b0, r_addr};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      val_q     <= '0;
      dty_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      cnt       <= '0;
      r_op      <= OP_LD;
      r_addr    <= '0;
      r_wdata   <= '0;
      r_idx     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          r_op    <= req_op;
          r_addr  <= req_addr[30:0];
          r_wdata <= req_wdata;
          r_idx   <= idx_in;
          cnt     <= '0;
          if (req_op == OP_FL) begin
            if (hit_in) begin
              if (dty_q[idx_in]) st <= S_WB;
              else val_q[idx_in] <= 1'b0;
            end
          end else if (byp_in) begin
            st <= S_BYP;
          end else if (hit_in) begin
            if (req_op == OP_LD) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dat_q[{idx_in, req_addr[3:2]}];
            end else begin
              dat_q[{idx_in, req_addr[3:2]}] <= req_wdata;
              dty_q[idx_in] <= 1'b1;
            end
          end else begin
            st <= (val_q[idx_in] && dty_q[idx_in]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack) begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            if (r_op == OP_FL) begin
              val_q[r_idx] <= 1'b0;
              dty_q[r_idx] <= 1'b0;
              st <= S_IDLE;
            end else begin
              st <= S_FILL;
            end
          end
        end
        S_FILL: if (mem_ack) begin
          dat_q[{r_idx, cnt}] <= mem_rdata;
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            tag_q[r_idx] <= r_addr[30:4];
            val_q[r_idx] <= 1'b1;
            dty_q[r_idx] <= 1'b0;
            st <= S_DONE;
          end
        end
        S_DONE: begin
          if (r_op == OP_LD) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dat_q[{r_idx, r_addr[3:2]}];
          end else begin
            dat_q[{r_idx, r_addr[3:2]}] <= r_wdata;
            dty_q[r_idx] <= 1'b1;
          end
          st <= S_IDLE;
        end
        S_BYP: if (mem_ack) begin
          if (r_op == OP_LD) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_rdata;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_store_hit_dirty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_ST && !byp_in && hit_in) |=> (dty_q[$past(idx_in)] && !mem_req));

  assert_bypass_no_touch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYP) |-> ($stable(val_q) && $stable(dty_q)));

  assert_flush_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && r_op == OP_FL && mem_ack && cnt == 2'd3) |=> (!val_q[$past(r_idx)] && req_ready));

  assert_off_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!EN && accept && req_op == OP_FL) |=> (req_ready && !mem_req));

  assert_bus_bit31_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_addr[31] && req_op != OP_FL) |=> (mem_req && !mem_addr[31]));
endmodule

// File: tb/wb_dcache_bench.sv
`timescale 1ns/1ps
module wb_dcache_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n;

  logic a_valid, a_ready, a_io, a_rspv, a_req, a_we, a_ack;
  logic [1:0] a_op;
  logic [31:0] a_addr_i, a_wd, a_rd, a_maddr, a_mwd, a_mrd;
  logic b_valid, b_ready, b_io, b_rspv, b_req, b_we, b_ack;
  logic [1:0] b_op;
  logic [31:0] b_addr_i, b_wd, b_rd, b_maddr, b_mwd, b_mrd;

  wb_dcache #(.LINES(16)) u_wb_dcache (
    .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready), .req_op(a_op),
    .req_io(a_io), .req_addr(a_addr_i), .req_wdata(a_wd), .rsp_valid(a_rspv), .rsp_rdata(a_rd),
    .mem_req(a_req), .mem_we(a_we), .mem_addr(a_maddr), .mem_wdata(a_mwd),
    .mem_ack(a_ack), .mem_rdata(a_mrd));

  wb_dcache #(.LINES(0)) u_wb_dcache_off (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready), .req_op(b_op),
    .req_io(b_io), .req_addr(b_addr_i), .req_wdata(b_wd), .rsp_valid(b_rspv), .rsp_rdata(b_rd),
    .mem_req(b_req), .mem_we(b_we), .mem_addr(b_maddr), .mem_wdata(b_mwd),
    .mem_ack(b_ack), .mem_rdata(b_mrd));

  logic [31:0] mem [1024];
  int tests = 0, fails = 0;
  int nrd, nwr, nlog, brd, bwr, bad31, unstable, long_pulse, lat_a, wait_a;
  logic [31:0] log_addr [16];
  logic        log_we [16];
  logic a_got, b_got, a_prev_rsp;
  logic [31:0] a_dat, b_dat, p_addr, p_wd;
  logic p_we;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    a_ack = 0; a_mrd = 0; wait_a = 0;
    forever begin
      @(negedge clk);
      if (a_ack) a_ack = 0;
      else if (a_req) begin
        if (a_maddr[31]) bad31++;
        if (wait_a > 0 && (a_maddr !== p_addr || a_we !== p_we || a_mwd !== p_wd)) unstable++;
        p_addr = a_maddr; p_we = a_we; p_wd = a_mwd;
        if (wait_a < lat_a) wait_a++;
        else begin
          wait_a = 0;
          a_ack = 1;
          a_mrd = mem[a_maddr[11:2]];
          if (a_we) begin mem[a_maddr[11:2]] = a_mwd; nwr++; end else nrd++;
          if (nlog < 16) begin log_addr[nlog] = a_maddr; log_we[nlog] = a_we; end
          nlog++;
        end
      end
    end
  end

  initial begin
    b_ack = 0; b_mrd = 0;
    forever begin
      @(negedge clk);
      if (b_ack) b_ack = 0;
      else if (b_req) begin
        b_ack = 1;
        b_mrd = mem[b_maddr[11:2]];
        if (b_we) begin mem[b_maddr[11:2]] = b_mwd; bwr++; end else brd++;
      end
    end
  end

  initial begin
    a_prev_rsp = 0;
    forever begin
      @(posedge clk); #1;
      if (a_rspv) begin a_got = 1; a_dat = a_rd; if (a_prev_rsp) long_pulse++; end
      a_prev_rsp = a_rspv;
      if (b_rspv) begin b_got = 1; b_dat = b_rd; end
    end
  end

  task automatic issue_a(input logic [1:0] op, input logic io, input logic [31:0] ad, input logic [31:0] wd);
    a_got = 0; nlog = 0; nrd = 0; nwr = 0;
    a_valid = 1; a_op = op; a_io = io; a_addr_i = ad; a_wd = wd;
    while (!a_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    a_valid = 0;
    if (op == 2'd0) while (!a_got) @(negedge clk);
    else while (!a_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue_b(input logic [1:0] op, input logic [31:0] ad, input logic [31:0] wd);
    b_got = 0; brd = 0; bwr = 0;
    b_valid = 1; b_op = op; b_io = 0; b_addr_i = ad; b_wd = wd;
    while (!b_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    b_valid = 0;
    if (op == 2'd0) while (!b_got) @(negedge clk);
    else while (!b_ready) @(negedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        io;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  nr;
    logic [3:0]  nw;
  } vec_t;

  localparam vec_t VEC [20] = '{
    '{2'd0, 1'b0, 32'h0000_0004, 32'h0, 32'hA000_0001, 4'd4, 4'd0},  // R2 R12 cold miss
    '{2'd0, 1'b0, 32'h0000_0008, 32'h0, 32'hA000_0002, 4'd0, 4'd0},  // hit
    '{2'd1, 1'b0, 32'h0000_0008, 32'h1111_1111, 32'h0, 4'd0, 4'd0},  // R1 store hit
    '{2'd0, 1'b0, 32'h0000_0008, 32'h0, 32'h1111_1111, 4'd0, 4'd0},  // R1
    '{2'd0, 1'b1, 32'h0000_0008, 32'h0, 32'hA000_0002, 4'd1, 4'd0},  // R6 R1 memory still old
    '{2'd1, 1'b1, 32'h0000_000C, 32'h2222_2222, 32'h0, 4'd0, 4'd1},  // R6
    '{2'd0, 1'b0, 32'h0000_000C, 32'h0, 32'hA000_0003, 4'd0, 4'd0},  // R6 cache untouched
    '{2'd0, 1'b0, 32'h8000_000C, 32'h0, 32'h2222_2222, 4'd1, 4'd0},  // R7
    '{2'd0, 1'b0, 32'h0000_0108, 32'h0, 32'hA000_0042, 4'd4, 4'd4},  // R3 dirty victim
    '{2'd0, 1'b0, 32'h0000_0008, 32'h0, 32'h1111_1111, 4'd4, 4'd0},  // R3 data survived
    '{2'd1, 1'b0, 32'h0000_0204, 32'h3333_3333, 32'h0, 4'd4, 4'd0},  // R2 write allocate
    '{2'd2, 1'b0, 32'h0000_0204, 32'h0, 32'h0, 4'd0, 4'd4},          // R4 dirty flush
    '{2'd0, 1'b0, 32'h0000_0204, 32'h0, 32'h3333_3333, 4'd4, 4'd0},  // R4 refill after flush
    '{2'd2, 1'b0, 32'h0000_0304, 32'h0, 32'h0, 4'd0, 4'd0},          // R5 tag mismatch
    '{2'd0, 1'b0, 32'h0000_0208, 32'h0, 32'hA000_0082, 4'd0, 4'd0},  // R5 line kept
    '{2'd2, 1'b0, 32'h0000_0204, 32'h0, 32'h0, 4'd0, 4'd0},          // R5 clean flush
    '{2'd0, 1'b0, 32'h0000_0200, 32'h0, 32'hA000_0080, 4'd4, 4'd0},  // R5 invalidated
    '{2'd1, 1'b0, 32'h8000_0204, 32'h4444_4444, 32'h0, 4'd0, 4'd1},  // R7 store bypass
    '{2'd0, 1'b0, 32'h0000_0204, 32'h0, 32'h3333_3333, 4'd0, 4'd0},  // R7 cache untouched
    '{2'd0, 1'b0, 32'h8000_0204, 32'h0, 32'h4444_4444, 4'd1, 4'd0}   // R7
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA000_0000 | i;
    rst_n = 0; lat_a = 0; bad31 = 0; unstable = 0; long_pulse = 0;
    a_valid = 0; a_op = 0; a_io = 0; a_addr_i = 0; a_wd = 0;
    b_valid = 0; b_op = 0; b_io = 0; b_addr_i = 0; b_wd = 0;
    nlog = 0; nrd = 0; nwr = 0; brd = 0; bwr = 0;
    repeat (3) @(negedge clk);
    chk("R12 ready in reset", {31'd0, a_ready}, 32'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R12 ready after reset", {31'd0, a_ready}, 32'd1);
    chk("R12 no mem_req", {31'd0, a_req}, 32'd0);
    chk("R12 no rsp", {31'd0, a_rspv}, 32'd0);

    for (int v = 0; v < 20; v++) begin
      issue_a(VEC[v].op, VEC[v].io, VEC[v].addr, VEC[v].wd);
      if (VEC[v].op == 2'd0) chk($sformatf("vec%0d data", v), a_dat, VEC[v].exp);
      chk($sformatf("vec%0d reads", v), nrd, {28'd0, VEC[v].nr});
      chk($sformatf("vec%0d writes", v), nwr, {28'd0, VEC[v].nw});
    end

    lat_a = 2;
    issue_a(2'd1, 1'b0, 32'h0000_0404, 32'h5555_5555);
    chk("R2 fill count", nlog, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R2 fill order", log_addr[k], 32'h400 + 4 * k);
      chk("R2 fill is read", {31'd0, log_we[k]}, 32'd0);
    end
    issue_a(2'd0, 1'b0, 32'h0000_0504, 32'h0);
    chk("R3 evict data", a_dat, 32'hA000_0141);
    chk("R3 evict count", nlog, 8);
    for (int k = 0; k < 4; k++) begin
      chk("R3 writeback order", log_addr[k], 32'h400 + 4 * k);
      chk("R3 writeback is write", {31'd0, log_we[k]}, 32'd1);
      chk("R3 refill order", log_addr[k + 4], 32'h500 + 4 * k);
      chk("R3 refill is read", {31'd0, log_we[k + 4]}, 32'd0);
    end
    chk("R3 victim in memory", mem[32'h101], 32'h5555_5555);

    mem[32'h141] = 32'h6666_6666;
    issue_a(2'd0, 1'b0, 32'h0000_0504, 32'h0);
    chk("R10 stale cached value", a_dat, 32'hA000_0141);
    chk("R10 no bus access", nlog, 0);

    chk("R8 bus bit31 zero", bad31, 0);
    chk("R9 request held", unstable, 0);
    chk("R13 single cycle pulse", long_pulse, 0);

    b_got = 0; brd = 0; bwr = 0;
    b_valid = 1; b_op = 2'd2; b_addr_i = 32'h10;
    @(posedge clk); @(negedge clk);
    b_valid = 0;
    chk("R11 flush ready next cycle", {31'd0, b_ready}, 32'd1);
    chk("R11 flush no bus", brd + bwr, 0);
    @(negedge clk);
    issue_b(2'd0, 32'h0000_0010, 32'h0);
    chk("R11 load data", b_dat, 32'hA000_0004);
    chk("R11 load one read", brd, 1);
    issue_b(2'd1, 32'h0000_0010, 32'h7777_7777);
    chk("R11 store one write", bwr, 1);
    issue_b(2'd0, 32'h0000_0010, 32'h0);
    chk("R11 reload from memory", b_dat, 32'h7777_7777);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule